// File: doc/BRIEF.md
# GPIO Pin Function and Direction Controller

This block holds the pin configuration for a bank-organised set of general-purpose pins (up to 128). For every pin it stores a 2-bit alternate-function code, a run-mode direction bit, a sleep-mode direction bit and a sleep-mode output level. Software reaches these through a small synchronous register bus: single-cycle writes, and reads that return data one clock after the read strobe.

The stored settings drive the pads directly. While `sleep_mode` is low, each pad's output enable follows the run-mode direction and its output level follows the `gpio_dout` vector supplied by the GPIO data logic. While `sleep_mode` is high, the sleep-direction and sleep-level registers take over. The function codes and a per-pin "acts as plain GPIO" flag go to the peripheral muxes downstream.

A contiguous range of pins (86 to 89 by default) uses reversed conventions. For those pins a direction bit of 0 means output, and function code 1, not 0, selects plain GPIO. Their reset values are set so that they also come out of reset as GPIO inputs.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset every pin is a GPIO input. All function fields and direction bits read 0, except pins 86–89, whose function code reads 1 and whose run and sleep direction bits read 1. Every bit of `pad_oe` is 0, every bit of `pin_is_gpio` is 1, and both sleep registers of every bank read 0 apart from those sleep-direction bits.
- R2: Pin p belongs to bank p>>5. Its function code sits in the low word of the bank when bit 4 of p is 0 and in the high word when it is 1, at bits [(p&15)*2+1 : (p&15)*2]. The same code appears on `func_sel[2p+1:2p]`.
- R3: For an ordinary pin with `sleep_mode` low, direction bit 1 drives `pad_oe` high and direction bit 0 drives it low.
- R4: For pins 86–89 the direction polarity is reversed, in run mode and in sleep mode: bit 0 drives `pad_oe` high.
- R5: `pin_is_gpio[p]` is 1 exactly when the function code of pin p is 0, or 1 for pins 86–89.
- R6: With `sleep_mode` low, `pad_out` equals `gpio_dout`. With `sleep_mode` high, `pad_oe` follows the sleep-direction register (same polarity rule) and `pad_out` follows the sleep-level bit, 1 meaning high.
- R7: A write updates the addressed word on the next clock edge. `bus_rdata` returns the addressed word on the clock edge that samples `bus_rd`, and holds it until the next read.
- R8: Writes to unimplemented pins, to banks beyond the last one, or to register kinds 5–7 have no effect. Reads of such positions return 0.
- R9: `bus_addr[2:0]` selects the register kind: 0 = function low word, 1 = function high word, 2 = run direction, 3 = sleep level, 4 = sleep direction. The upper address bits select the bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | {bank, register kind} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sleep_mode | input | 1 | Selects sleep-mode pad settings |
| gpio_dout | input | NUM_PINS | Run-mode output levels from GPIO data logic |
| pad_oe | output | NUM_PINS | Per-pin pad output enable |
| pad_out | output | NUM_PINS | Per-pin pad output level |
| func_sel | output | 2*NUM_PINS | Per-pin alternate-function code |
| pin_is_gpio | output | NUM_PINS | Pin operates as plain GPIO |

## Verification
Every cycle, the assertions check the following:
- the pad output tracks `gpio_dout` outside sleep;
- a function-word write or a bank-0 direction write appears on the next cycle at `func_sel` or `pad_oe`;
- accesses to register kinds 5–7 change nothing and read as 0;
- pads come out of reset as inputs.

The table walk and the directed tests cover what depends on a particular pin number or bank layout:
- the reversed polarity and GPIO code of pins 86–89;
- the masking of the unimplemented bits in the last bank;
- the swap to the sleep registers and back;
- the reset pattern of the reversed pins.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int BANK_PINS = 32;
    localparam int FUNC_W    = 2;

    typedef enum logic [2:0] {
        KIND_FUNC_LO = 3'd0,
        KIND_FUNC_HI = 3'd1,
        KIND_DIR     = 3'd2,
        KIND_SLP_LVL = 3'd3,
        KIND_SLP_DIR = 3'd4
    } reg_kind_e;

endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PAD_PINS  = 96,
    parameter int ADDR_W    = 5,
    parameter logic [PAD_PINS-1:0]   IMPL_MASK = '1,
    parameter logic [PAD_PINS-1:0]   INV_MASK  = '0,
    parameter logic [2*PAD_PINS-1:0] FUNC_MASK = '1,
    parameter logic [2*PAD_PINS-1:0] FUNC_RST  = '0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [31:0]           rd_word,
    output logic [2*PAD_PINS-1:0] func_q,
    output logic [PAD_PINS-1:0]   dir_q,
    output logic [PAD_PINS-1:0]   slvl_q,
    output logic [PAD_PINS-1:0]   sdir_q,
    output logic [31:0]           rdata_q
);

    typedef struct packed {
        logic [2*PAD_PINS-1:0] func;
        logic [PAD_PINS-1:0]   dir;
        logic [PAD_PINS-1:0]   slvl;
        logic [PAD_PINS-1:0]   sdir;
        logic [31:0]           rdata;
    } regs_t;

    localparam regs_t RST_VAL = '{
        func:  FUNC_RST,
        dir:   INV_MASK,
        slvl:  '0,
        sdir:  INV_MASK,
        rdata: '0
    };

    regs_t regs_d, regs_q;

    always_comb begin
        int b;
        regs_d = regs_q;
        b = int'(addr[ADDR_W-1:3]);
        if (wr && b < NUM_BANKS) begin
            case (addr[2:0])
                KIND_FUNC_LO: regs_d.func[b*64 +: 32]      = wdata;
                KIND_FUNC_HI: regs_d.func[b*64 + 32 +: 32] = wdata;
                KIND_DIR:     regs_d.dir[b*32 +: 32]       = wdata;
                KIND_SLP_LVL: regs_d.slvl[b*32 +: 32]      = wdata;
                KIND_SLP_DIR: regs_d.sdir[b*32 +: 32]      = wdata;
                default: ;
            endcase
        end
        regs_d.func = regs_d.func & FUNC_MASK;
        regs_d.dir  = regs_d.dir  & IMPL_MASK;
        regs_d.slvl = regs_d.slvl & IMPL_MASK;
        regs_d.sdir = regs_d.sdir & IMPL_MASK;
        if (rd) regs_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= RST_VAL;
        else        regs_q <= regs_d;
    end

    assign func_q  = regs_q.func;
    assign dir_q   = regs_q.dir;
    assign slvl_q  = regs_q.slvl;
    assign sdir_q  = regs_q.sdir;
    assign rdata_q = regs_q.rdata;

endmodule

// File: rtl/pinmux_rdmux.sv
module pinmux_rdmux
    import pinmux_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PAD_PINS  = 96,
    parameter int ADDR_W    = 5
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*PAD_PINS-1:0] func_q,
    input  logic [PAD_PINS-1:0]   dir_q,
    input  logic [PAD_PINS-1:0]   slvl_q,
    input  logic [PAD_PINS-1:0]   sdir_q,
    output logic [31:0]           word
);

    always_comb begin
        int b;
        word = '0;
        b = int'(addr[ADDR_W-1:3]);
        if (b < NUM_BANKS) begin
            case (addr[2:0])
                KIND_FUNC_LO: word = func_q[b*64 +: 32];
                KIND_FUNC_HI: word = func_q[b*64 + 32 +: 32];
                KIND_DIR:     word = dir_q[b*32 +: 32];
                KIND_SLP_LVL: word = slvl_q[b*32 +: 32];
                KIND_SLP_DIR: word = sdir_q[b*32 +: 32];
                default:      word = '0;
            endcase
        end
    end

endmodule

// File: rtl/pinmux_pad.sv
module pinmux_pad
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 90,
    parameter logic [NUM_PINS-1:0] INV_MASK = '0
) (
    input  logic                  sleep_mode,
    input  logic [2*NUM_PINS-1:0] func_q,
    input  logic [NUM_PINS-1:0]   dir_q,
    input  logic [NUM_PINS-1:0]   slvl_q,
    input  logic [NUM_PINS-1:0]   sdir_q,
    input  logic [NUM_PINS-1:0]   gpio_dout,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [2*NUM_PINS-1:0] func_sel,
    output logic [NUM_PINS-1:0]   pin_is_gpio
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam logic       REV      = INV_MASK[i];
        localparam logic [1:0] GPIO_CODE = REV ? 2'd1 : 2'd0;
        logic run_oe, slp_oe;
        assign run_oe         = dir_q[i]  ^ REV;
        assign slp_oe         = sdir_q[i] ^ REV;
        assign pad_oe[i]      = sleep_mode ? slp_oe    : run_oe;
        assign pad_out[i]     = sleep_mode ? slvl_q[i] : gpio_dout[i];
        assign func_sel[2*i +: FUNC_W] = func_q[2*i +: FUNC_W];
        assign pin_is_gpio[i] = (func_q[2*i +: FUNC_W] == GPIO_CODE);
    end

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS  = 90,
    parameter int INV_FIRST = 86,
    parameter int INV_LAST  = 89,
    localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ADDR_W    = BANK_W + 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic                  sleep_mode,
    input  logic [NUM_PINS-1:0]   gpio_dout,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [2*NUM_PINS-1:0] func_sel,
    output logic [NUM_PINS-1:0]   pin_is_gpio
);

    localparam int PAD_PINS = NUM_BANKS * BANK_PINS;

    function automatic logic [PAD_PINS-1:0] mk_impl();
        logic [PAD_PINS-1:0] m;
        for (int i = 0; i < PAD_PINS; i++) m[i] = (i < NUM_PINS);
        return m;
    endfunction

    function automatic logic [PAD_PINS-1:0] mk_inv();
        logic [PAD_PINS-1:0] m;
        for (int i = 0; i < PAD_PINS; i++)
            m[i] = (i >= INV_FIRST) && (i <= INV_LAST) && (i < NUM_PINS);
        return m;
    endfunction

    localparam logic [PAD_PINS-1:0] IMPL_MASK = mk_impl();
    localparam logic [PAD_PINS-1:0] INV_MASK  = mk_inv();

    function automatic logic [2*PAD_PINS-1:0] mk_func_mask();
        logic [2*PAD_PINS-1:0] m;
        for (int i = 0; i < PAD_PINS; i++) m[2*i +: 2] = {2{IMPL_MASK[i]}};
        return m;
    endfunction

    function automatic logic [2*PAD_PINS-1:0] mk_func_rst();
        logic [2*PAD_PINS-1:0] m;
        for (int i = 0; i < PAD_PINS; i++) m[2*i +: 2] = {1'b0, INV_MASK[i]};
        return m;
    endfunction

    localparam logic [2*PAD_PINS-1:0] FUNC_MASK = mk_func_mask();
    localparam logic [2*PAD_PINS-1:0] FUNC_RST  = mk_func_rst();

    logic [2*PAD_PINS-1:0] func_q;
    logic [PAD_PINS-1:0]   dir_q, slvl_q, sdir_q;
    logic [31:0]           rd_word;

    pinmux_regs #(
        .NUM_BANKS(NUM_BANKS), .PAD_PINS(PAD_PINS), .ADDR_W(ADDR_W),
        .IMPL_MASK(IMPL_MASK), .INV_MASK(INV_MASK),
        .FUNC_MASK(FUNC_MASK), .FUNC_RST(FUNC_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd),
        .addr(bus_addr), .wdata(bus_wdata), .rd_word(rd_word),
        .func_q(func_q), .dir_q(dir_q), .slvl_q(slvl_q), .sdir_q(sdir_q),
        .rdata_q(bus_rdata)
    );

    pinmux_rdmux #(
        .NUM_BANKS(NUM_BANKS), .PAD_PINS(PAD_PINS), .ADDR_W(ADDR_W)
    ) u_rdmux (
        .addr(bus_addr), .func_q(func_q), .dir_q(dir_q),
        .slvl_q(slvl_q), .sdir_q(sdir_q), .word(rd_word)
    );

    pinmux_pad #(
        .NUM_PINS(NUM_PINS), .INV_MASK(INV_MASK[NUM_PINS-1:0])
    ) u_pad (
        .sleep_mode(sleep_mode),
        .func_q(func_q[2*NUM_PINS-1:0]),
        .dir_q(dir_q[NUM_PINS-1:0]),
        .slvl_q(slvl_q[NUM_PINS-1:0]),
        .sdir_q(sdir_q[NUM_PINS-1:0]),
        .gpio_dout(gpio_dout),
        .pad_oe(pad_oe), .pad_out(pad_out),
        .func_sel(func_sel), .pin_is_gpio(pin_is_gpio)
    );

endmodule

// File: rtl/pinmux_ctrl_chk.sv
module pinmux_ctrl_chk
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 90,
    parameter int ADDR_W   = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic                  sleep_mode,
    input logic [NUM_PINS-1:0]   gpio_dout,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [2*NUM_PINS-1:0] func_sel,
    input logic [NUM_PINS-1:0]   pin_is_gpio
);

    assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0));

    assert_run_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_mode |-> (pad_out == gpio_dout));

    assert_bad_kind_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[2:0] > 3'd4) |=> (bus_rdata == 32'd0));

    assert_bad_kind_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[2:0] > 3'd4) |=> ($stable(func_sel) && $stable(pin_is_gpio)));

    if (NUM_PINS >= 32) begin : g_bank0
        assert_func_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == '0) |=> (func_sel[31:0] == $past(bus_wdata)));

        assert_run_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == ADDR_W'(KIND_DIR) && !sleep_mode)
            |=> (sleep_mode || pad_oe[31:0] == $past(bus_wdata)));
    end

endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sleep_mode(sleep_mode), .gpio_dout(gpio_dout), .pad_oe(pad_oe),
    .pad_out(pad_out), .func_sel(func_sel), .pin_is_gpio(pin_is_gpio)
);

// File: tb/pinmux_ctrl_test.sv
module pinmux_ctrl_test;

    localparam int NP = 90;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          sleep_mode = 1'b0;
    logic [NP-1:0] gpio_dout = '0;
    logic [NP-1:0] pad_oe, pad_out, pin_is_gpio;
    logic [2*NP-1:0] func_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pinmux_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sleep_mode(sleep_mode), .gpio_dout(gpio_dout), .pad_oe(pad_oe),
        .pad_out(pad_out), .func_sel(func_sel), .pin_is_gpio(pin_is_gpio)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [31:0]   wdata;
        logic [31:0]   exp;
    } vec_t;

    // addr = {bank, kind}; kinds per R9
    localparam vec_t VECS [10] = '{
        '{5'b00_000, 32'hA5A5_1234, 32'hA5A5_1234},
        '{5'b00_001, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        '{5'b01_010, 32'h8000_0001, 32'h8000_0001},
        '{5'b10_010, 32'hFFFF_FFFF, 32'h03FF_FFFF},
        '{5'b10_001, 32'hFFFF_FFFF, 32'h000F_FFFF},
        '{5'b10_011, 32'hFFFF_FFFF, 32'h03FF_FFFF},
        '{5'b11_010, 32'hFFFF_FFFF, 32'h0000_0000},
        '{5'b00_101, 32'hFFFF_FFFF, 32'h0000_0000},
        '{5'b01_100, 32'h1234_5678, 32'h1234_5678},
        '{5'b10_000, 32'h0000_0003, 32'h0000_0003}
    };

    task automatic chk(input string tag, input logic [191:0] got, input logic [191:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [NP-1:0] exp_oe;
        do_reset();

        // R1: reset state
        chk("R1 pad_oe", 192'(pad_oe), 192'(0));
        chk("R1 pin_is_gpio", 192'(pin_is_gpio), 192'({NP{1'b1}}));
        rd(5'b00_010, d); chk("R1 dir bank0", 192'(d), 192'(0));
        rd(5'b10_010, d); chk("R1 dir bank2 reversed", 192'(d), 192'(32'h03C0_0000));
        rd(5'b10_001, d); chk("R1 func hi bank2", 192'(d), 192'(32'h0005_5000));
        rd(5'b10_100, d); chk("R1 sleep dir bank2", 192'(d), 192'(32'h03C0_0000));
        rd(5'b01_011, d); chk("R1 sleep lvl bank1", 192'(d), 192'(0));

        // R7 R9 R8: table walk, write then read back
        for (int i = 0; i < 10; i++) begin
            wr(VECS[i].addr, VECS[i].wdata);
            rd(VECS[i].addr, d);
            chk($sformatf("R7 R9 R8 vector %0d", i), 192'(d), 192'(VECS[i].exp));
        end

        do_reset();

        // R2: pin 53 -> bank1 high word, bits 11:10
        wr(5'b01_001, 32'h0000_0800);
        chk("R2 func_sel pin53", 192'(func_sel[107:106]), 192'(2'd2));
        chk("R5 pin_is_gpio 52..54", 192'(pin_is_gpio[54:52]), 192'(3'b101));

        // R3: ordinary pin direction
        wr(5'b00_010, 32'h0000_0010);
        chk("R3 pad_oe pin4", 192'(pad_oe), 192'(90'h10));

        // R4: reversed pins become outputs on 0
        wr(5'b10_010, 32'h0000_0000);
        exp_oe = (90'hF << 86) | 90'h10;
        chk("R4 pad_oe reversed", 192'(pad_oe), 192'(exp_oe));

        // R5: reversed pins use code 1 for GPIO
        wr(5'b10_001, 32'h0000_1000);
        chk("R5 gpio flag 86..89", 192'(pin_is_gpio[89:86]), 192'(4'b0001));

        // R6: run vs sleep
        gpio_dout = {3{30'h2AAA_5555}};
        @(negedge clk);
        chk("R6 run pad_out", 192'(pad_out), 192'(gpio_dout));
        wr(5'b00_011, 32'h0000_00F0);
        wr(5'b00_100, 32'h0000_0030);
        sleep_mode = 1'b1;
        @(negedge clk);
        chk("R6 sleep pad_oe", 192'(pad_oe), 192'(90'h30));
        chk("R6 sleep pad_out", 192'(pad_out), 192'(90'hF0));
        wr(5'b10_100, 32'h0000_0000);
        chk("R4 R6 sleep reversed oe", 192'(pad_oe), 192'((90'hF << 86) | 90'h30));
        sleep_mode = 1'b0;
        @(negedge clk);
        chk("R6 back to run oe", 192'(pad_oe), 192'(exp_oe));

        // R8: ignored writes
        wr(5'b11_010, 32'hFFFF_FFFF);
        wr(5'b00_110, 32'hFFFF_FFFF);
        chk("R8 pad_oe unchanged", 192'(pad_oe), 192'(exp_oe));
        rd(5'b00_010, d); chk("R8 bank0 dir unchanged", 192'(d), 192'(32'h10));
        rd(5'b00_110, d); chk("R8 kind6 reads 0", 192'(d), 192'(0));
        chk("R8 func_sel unchanged", 192'(func_sel[31:0]), 192'(0));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule